// File: doc/BRIEF.md
# Rate-Divided Linear Hub Streaming FIFO

This block prefetches consecutive words from a shared hub memory into a small local buffer and releases them to a consumer at a programmable pace of one word every N system clocks. The consumer may be a pixel output path or a pipe that executes code in a straight line. After a restart with a start address, the block issues hub read requests at strictly increasing addresses whenever the buffer has room for the returning word.

A restart models a jump. It throws away everything buffered, discards every read that is still outstanding when its data returns, and begins fetching again from the new address. The consumer therefore waits for a full refill. When a word is due and the buffer is empty, the block raises an underflow flag and holds the output until data arrives; it never repeats a word.

The hub side is a plain request/grant port. A request is accepted in a cycle where `hubReq` and `hubGnt` are both high. Read data returns in request order, each word marked by one `hubRdValid` pulse, after any latency.

Top module: `hubstream_fifo`

## Requirements
- R1: After reset, and until the first restart, `hubReq`, `outValid` and `underflow` stay low.
- R2: After a restart to address S, the k-th accepted hub request (k counted from 0) carries address S+k modulo 2^ADDR_W. `hubReq` is low in the restart cycle.
- R3: The number of words buffered plus the number of live reads in flight never exceeds DEPTH (16). With the consumer disabled, exactly 16 requests are accepted after a restart, and then `hubReq` stays low.
- R4: Output words appear on `outData` in address order, starting at the restart address, each exactly once.
- R5: While data is available, `outValid` pulses exactly N cycles apart, where N is `rateDiv`.
- R6: A `rateDiv` of 0 behaves as 1: one word per clock.
- R7: When a word is due and the buffer is empty, `underflow` is high and `outValid` is low. The word is released in the cycle after it is written.
- R8: A restart empties the buffer, so the first word released afterwards comes from the new address.
- R9: Read data for requests accepted before a restart is dropped and never released.
- R10: While `streamEn` is low, no word is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| restartValid | input | 1 | Flush and restart fetching at restartAddr |
| restartAddr | input | ADDR_W (16) | New start address |
| rateDiv | input | DIV_W (8) | Output rate divider N (0 treated as 1) |
| streamEn | input | 1 | Consumer enable |
| hubReq | output | 1 | Hub read request |
| hubAddr | output | ADDR_W (16) | Hub read address |
| hubGnt | input | 1 | Hub accepts the request this cycle |
| hubRdValid | input | 1 | Returned read data valid |
| hubRdData | input | DATA_W (32) | Returned read data |
| outValid | output | 1 | Output word valid (one-cycle pulse) |
| outData | output | DATA_W (32) | Output word |
| underflow | output | 1 | A word is due but the buffer is empty |

## Verification
The main path is exercised with an always-granting hub at dividers 1, 3, 2 and 0. These runs separate correct pacing from off-by-one divider counts, and they confirm that a divider of 0 is handled the same as a divider of 1. One start address sits just below the top of the address space, to expose wrong address wrap. Hubs that grant every second or every fourth cycle starve the consumer, which proves that underflow stalls the output instead of repeating stale words. Directed runs cover the following cases:
- a restart while reads are in flight, which tells dropped responses apart from leaked ones;
- a disabled consumer, which shows whether the request limit stops at exactly the buffer depth.

// File: rtl/hubstream_pkg.sv
`timescale 1ns/1ps
package hubstream_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoCtl_t;
endpackage

// File: rtl/hubstream_dpath.sv
`timescale 1ns/1ps
module hubstream_dpath
  import hubstream_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCtl_t          ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (ctl.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      rdData <= '0;
    end else if (ctl.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (ctl.push) wrPtr <= nextPtr(wrPtr);
      if (ctl.pop) begin
        rdPtr  <= nextPtr(rdPtr);
        rdData <= mem[rdPtr];
      end
      count <= count + CNT_W'(ctl.push) - CNT_W'(ctl.pop);
    end
  end
endmodule

// File: rtl/hubstream_ctrl.sv
`timescale 1ns/1ps
module hubstream_ctrl
  import hubstream_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIV_W  = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restartValid,
  input  logic [ADDR_W-1:0] restartAddr,
  input  logic [DIV_W-1:0]  rateDiv,
  input  logic              streamEn,
  input  logic              hubGnt,
  input  logic              hubRdValid,
  input  logic [CNT_W-1:0]  fifoCount,
  output logic              hubReq,
  output logic [ADDR_W-1:0] hubAddr,
  output logic              outValid,
  output logic              underflow,
  output fifoCtl_t          ctl
);
  logic             active;
  logic [CNT_W-1:0] inFlight, dropCnt, liveInFlight;
  logic [DIV_W-1:0] divCnt, divLast;
  logic             space, grant, due;

  assign liveInFlight = inFlight - dropCnt;
  assign space   = ({1'b0, fifoCount} + {1'b0, liveInFlight}) < (CNT_W + 1)'(DEPTH);
  assign hubReq  = active && !restartValid && space;
  assign grant   = hubReq && hubGnt;
  assign divLast = (rateDiv == '0) ? '0 : rateDiv - 1'b1;
  assign due     = active && streamEn && !restartValid && (divCnt >= divLast);

  always_comb begin
    ctl.flush = restartValid;
    ctl.push  = hubRdValid && (dropCnt == '0) && !restartValid;
    ctl.pop   = due && (fifoCount != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      hubAddr   <= '0;
      inFlight  <= '0;
      dropCnt   <= '0;
      divCnt    <= '0;
      outValid  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      inFlight  <= inFlight + CNT_W'(grant) - CNT_W'(hubRdValid);
      outValid  <= ctl.pop;
      underflow <= due && (fifoCount == '0);
      if (restartValid) begin
        active  <= 1'b1;
        hubAddr <= restartAddr;
        dropCnt <= inFlight - CNT_W'(hubRdValid);
        divCnt  <= '0;
      end else begin
        if (grant) hubAddr <= hubAddr + 1'b1;
        if (hubRdValid && dropCnt != '0) dropCnt <= dropCnt - 1'b1;
        if (active && streamEn) begin
          if (!due)          divCnt <= divCnt + 1'b1;
          else if (ctl.pop)  divCnt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/hubstream_fifo.sv
`timescale 1ns/1ps
module hubstream_fifo
  import hubstream_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restartValid,
  input  logic [ADDR_W-1:0] restartAddr,
  input  logic [DIV_W-1:0]  rateDiv,
  input  logic              streamEn,
  output logic              hubReq,
  output logic [ADDR_W-1:0] hubAddr,
  input  logic              hubGnt,
  input  logic              hubRdValid,
  input  logic [DATA_W-1:0] hubRdData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              underflow
);
  fifoCtl_t         ctl;
  logic [CNT_W-1:0] fifoCount;

  hubstream_ctrl #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .restartValid(restartValid), .restartAddr(restartAddr),
    .rateDiv(rateDiv), .streamEn(streamEn), .hubGnt(hubGnt), .hubRdValid(hubRdValid),
    .fifoCount(fifoCount), .hubReq(hubReq), .hubAddr(hubAddr), .outValid(outValid),
    .underflow(underflow), .ctl(ctl)
  );

  hubstream_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(hubRdData),
    .count(fifoCount), .rdData(outData)
  );
endmodule

// File: rtl/hubstream_chk.sv
`timescale 1ns/1ps
module hubstream_chk #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              restartValid,
  input logic              streamEn,
  input logic              hubReq,
  input logic              hubGnt,
  input logic [ADDR_W-1:0] hubAddr,
  input logic              outValid,
  input logic              underflow,
  input logic [CNT_W-1:0]  fifoCount
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH));
  a_r3_full_no_req: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == CNT_W'(DEPTH)) |-> !hubReq);
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (hubReq && hubGnt && !restartValid) |=> (hubAddr == $past(hubAddr) + 1'b1));
  a_r2_restart_no_req: assert property (@(posedge clk) disable iff (!rstN)
    restartValid |-> !hubReq);
  a_r8_flush: assert property (@(posedge clk) disable iff (!rstN)
    restartValid |=> (fifoCount == '0));
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && underflow));
  a_r10_idle: assert property (@(posedge clk) disable iff (!rstN)
    !streamEn |=> !outValid);
endmodule

bind hubstream_fifo hubstream_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .restartValid(restartValid), .streamEn(streamEn),
  .hubReq(hubReq), .hubGnt(hubGnt), .hubAddr(hubAddr), .outValid(outValid),
  .underflow(underflow), .fifoCount(fifoCount)
);

// File: tb/hubstream_fifo_tb_top.sv
`timescale 1ns/1ps
module hubstream_fifo_tb_top;
  // vector fields: [33:18] start address, [17:10] divider, [9:8] grant mode, [7:0] words
  localparam int NVEC = 6;
  localparam logic [33:0] VEC [NVEC] = '{
    {16'h0100, 8'd1, 2'd0, 8'd24},
    {16'h2000, 8'd3, 2'd0, 8'd20},
    {16'hFFF8, 8'd2, 2'd0, 8'd20},
    {16'h0040, 8'd0, 2'd0, 8'd20},
    {16'h0500, 8'd1, 2'd1, 8'd12},
    {16'h7000, 8'd5, 2'd2, 8'd10}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic restartValid = 1'b0;
  logic [15:0] restartAddr = '0;
  logic [7:0]  rateDiv = 8'd1;
  logic streamEn = 1'b0;
  logic hubReq, hubGnt = 1'b0, hubRdValid = 1'b0;
  logic [15:0] hubAddr;
  logic [31:0] hubRdData = '0;
  logic outValid, underflow;
  logic [31:0] outData;

  hubstream_fifo dut_i (
    .clk(clk), .rstN(rstN), .restartValid(restartValid), .restartAddr(restartAddr),
    .rateDiv(rateDiv), .streamEn(streamEn), .hubReq(hubReq), .hubAddr(hubAddr),
    .hubGnt(hubGnt), .hubRdValid(hubRdValid), .hubRdData(hubRdData),
    .outValid(outValid), .outData(outData), .underflow(underflow)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0, grantCount = 0;
  int gntMode = 0;
  logic pv [3];
  logic [31:0] pd [3];
  logic obsValid, obsUnder;
  logic [31:0] obsData;
  logic chkAddr = 1'b0;
  logic [15:0] nextAddr = '0;
  bit finished = 0;

  function automatic logic [31:0] dataOf(input logic [15:0] a);
    return {a, ~a};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit rst);
    @(negedge clk);
    obsValid = outValid; obsData = outData; obsUnder = underflow;
    hubRdValid = pv[2]; hubRdData = pd[2];
    pv[2] = pv[1]; pd[2] = pd[1];
    pv[1] = pv[0]; pd[1] = pd[0];
    pv[0] = 1'b0;
    case (gntMode)
      1: hubGnt = (cyc % 4) == 0;
      2: hubGnt = (cyc % 2) == 0;
      default: hubGnt = 1'b1;
    endcase
    restartValid = rst;
    #1;
    if (hubReq && hubGnt) begin
      pv[0] = 1'b1; pd[0] = dataOf(hubAddr); grantCount++;
      if (chkAddr) begin
        check(hubAddr == nextAddr, "R2 request address", 32'(hubAddr), 32'(nextAddr));
        nextAddr = nextAddr + 1'b1;
      end
    end
    cyc++;
  endtask

  task automatic collect(input logic [15:0] start, input int nWords, input int spacing, input bit chkSpace, output int ufSeen);
    int got = 0, lastT = 0;
    ufSeen = 0;
    for (int t = 0; t < 3000 && got < nWords; t++) begin
      step(0);
      if (obsUnder) begin
        ufSeen++;
        check(!obsValid, "R7 no word during underflow", 32'(obsValid), 32'd0);
      end
      if (obsValid) begin
        check(obsData == dataOf(start + 16'(got)), "R4/R8 word order", obsData, dataOf(start + 16'(got)));
        if (chkSpace && got > 0)
          check(cyc - lastT == spacing, "R5/R6 spacing", 32'(cyc - lastT), 32'(spacing));
        lastT = cyc;
        got++;
      end
    end
    check(got == nWords, "R4 word count", 32'(got), 32'(nWords));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int uf;
    logic [33:0] e;
    int nExp;
    for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pd[i] = '0; end
    repeat (3) step(0);
    check(!hubReq && !outValid && !underflow, "R1 in reset", {29'd0, hubReq, outValid, underflow}, 32'd0);
    @(negedge clk); rstN = 1'b1;
    streamEn = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step(0);
      check(!hubReq && !obsValid && !obsUnder, "R1 idle before restart",
            {29'd0, hubReq, obsValid, obsUnder}, 32'd0);
    end

    // table-driven stream runs
    for (int v = 0; v < NVEC; v++) begin
      e = VEC[v];
      rateDiv = e[17:10]; restartAddr = e[33:18]; gntMode = int'(e[9:8]);
      nExp = (e[17:10] == 0) ? 1 : int'(e[17:10]);
      step(1);
      collect(e[33:18], int'(e[7:0]), nExp, e[9:8] == 2'd0, uf);
      if (e[9:8] == 2'd1)
        check(uf > 0, "R7 underflow flagged", 32'(uf), 32'd1);
    end

    // R3 / R10: consumer off, request count limited to depth, addresses consecutive
    streamEn = 1'b0; gntMode = 0; rateDiv = 8'd1; restartAddr = 16'h4000;
    step(1);
    grantCount = 0; chkAddr = 1'b1; nextAddr = 16'h4000;
    for (int i = 0; i < 40; i++) begin
      step(0);
      if (obsValid) check(1'b0, "R10 output while disabled", 32'd1, 32'd0);
    end
    chkAddr = 1'b0;
    check(grantCount == 16, "R3 request limit", 32'(grantCount), 32'd16);
    check(!hubReq, "R3 request low when full", 32'(hubReq), 32'd0);
    streamEn = 1'b1;
    collect(16'h4000, 20, 1, 1'b0, uf);

    // R9: restart with reads in flight
    restartAddr = 16'h3000; rateDiv = 8'd1;
    step(1);
    repeat (6) step(0);
    restartAddr = 16'h3800;
    step(1);
    collect(16'h3800, 10, 1, 1'b1, uf);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule